// File: doc/BRIEF.md
# Chopper Control Frame Sequencer

This block paces the multiplexer of a metering front end on a slow (32 kHz class) clock and drives the chopping control of a reference amplifier. It counts multiplexer states inside a frame and frames inside an accumulation interval. After the last state of every frame it adds one settle cycle. In that cycle the chop polarity takes its new value, so the chopped reference has time to settle. A frame-sync output is high for that whole cycle, and its rising edge starts a downstream processing pass.

A two-bit mode input chooses the polarity behaviour: held low (01), held high (10), or automatic toggling (00, and 11 acts the same way). In the toggling modes the last frame of each interval is forced to be an alternate (temperature) frame. The polarity flip that would come just before that frame is skipped. With an even frame count, the alternate frames of successive intervals therefore see opposite polarity, and their offset error averages out. States-per-frame and frames-per-interval are captured while reset is held, and each must be at least 2. A production interval uses 2520 frames.

Top module: `chop_frame_seq`

## Requirements
- R1: While reset (rstN low) is held, chopPol, chopClk, frameSync and altFrame are 0 and frameIdx is 1.
- R2: A frame lasts statesPerFrame clock cycles. It is followed by exactly one settle cycle in which frameSync is 1, and frameSync is 0 at all other times.
- R3: chopPol changes only on the clock edge that starts a settle cycle. A change of modeSel takes effect only at the next settle cycle.
- R4: When modeSel is 2'b01 at the start of a settle cycle, chopPol and chopClk become 0. When modeSel is 2'b10, both become 1.
- R5: In mode 2'b00, chopPol inverts at the start of every settle cycle, except the settle cycle that follows frame framesPerInterval-1.
- R6: altFrame is 1 for every cycle of frame framesPerInterval when the mode in force is a toggling mode. It is 0 during settle cycles and while a fixed mode is in force.
- R7: In mode 2'b00 with an even framesPerInterval, the alternate frames of two consecutive intervals have opposite chopPol.
- R8: Mode 2'b11 behaves identically to mode 2'b00.
- R9: frameIdx counts 1 to framesPerInterval. It advances at the end of each settle cycle and wraps from framesPerInterval back to 1.
- R10: statesPerFrame and framesPerInterval are sampled only while reset is held. Changes after reset have no effect on the frame or interval length.
- R11: chopClk always equals chopPol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (32 kHz class) |
| rstN | input | 1 | Synchronous active-low reset; also captures the frame geometry |
| modeSel | input | 2 | Chop mode: 00/11 toggle, 01 low, 10 high |
| statesPerFrame | input | STATE_W | Multiplexer states per frame (at least 2) |
| framesPerInterval | input | FRAME_W | Frames per accumulation interval (at least 2) |
| chopPol | output | 1 | Chop polarity to the reference amplifier switches |
| chopClk | output | 1 | Chop clock level |
| frameSync | output | 1 | High for the whole settle cycle after each frame |
| altFrame | output | 1 | High during the forced alternate frame |
| frameIdx | output | FRAME_W | Current frame number, 1-based |

## Verification
The bench goes after the skipped toggle before the alternate frame. A design that flipped there would give the alternate frames of both intervals the same polarity, so the offset would never average out. It also changes the mode in the middle of a frame and checks that the polarity waits for the settle edge, which catches a design that reacts combinationally. It changes the geometry inputs after reset, which catches a design that reads them live; such a design would shift every frame boundary. Finally it runs mode 11 and the fixed modes, which exposes a mode decoder that treats 11 as fixed, or one that raises the alternate flag while the polarity is held.

// File: rtl/chop_seq_pkg.sv
package chop_seq_pkg;
  typedef enum logic [1:0] {
    MODE_AUTO_A = 2'b00,
    MODE_LOW    = 2'b01,
    MODE_HIGH   = 2'b10,
    MODE_AUTO_B = 2'b11
  } chopMode_e;

  typedef struct packed {
    logic enterSettle;  // this edge ends a frame and starts a settle cycle
    logic preAlt;       // the frame now ending is the one before the alternate frame
  } seqStrobe_t;
endpackage

// File: rtl/chop_seq_ctrl.sv
module chop_seq_ctrl
  import chop_seq_pkg::*;
#(
  parameter int STATE_W = 8,
  parameter int FRAME_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STATE_W-1:0] statesPerFrame,
  input  logic [FRAME_W-1:0] framesPerInterval,
  input  logic               autoMode,
  output seqStrobe_t         strobe,
  output logic               frameSync,
  output logic               altFrame,
  output logic [FRAME_W-1:0] frameIdx
);
  localparam logic [STATE_W-1:0] STATE_ONE = STATE_W'(1);
  localparam logic [FRAME_W-1:0] FRAME_ONE = FRAME_W'(1);

  logic [STATE_W-1:0] spfLat;
  logic [FRAME_W-1:0] fpiLat;
  logic [STATE_W-1:0] stateCnt;
  logic               settle;
  logic               frameEnd;
  logic               lastFrame;

  assign frameEnd  = (stateCnt == spfLat - STATE_ONE);
  assign lastFrame = (frameIdx == fpiLat);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spfLat   <= statesPerFrame;
      fpiLat   <= framesPerInterval;
      stateCnt <= '0;
      settle   <= 1'b0;
      frameIdx <= FRAME_ONE;
    end else if (settle) begin
      settle   <= 1'b0;
      frameIdx <= lastFrame ? FRAME_ONE : frameIdx + FRAME_ONE;
    end else if (frameEnd) begin
      settle   <= 1'b1;
      stateCnt <= '0;
    end else begin
      stateCnt <= stateCnt + STATE_ONE;
    end
  end

  assign strobe.enterSettle = !settle && frameEnd;
  assign strobe.preAlt      = (frameIdx == fpiLat - FRAME_ONE);
  assign frameSync          = settle;
  assign altFrame           = autoMode && !settle && lastFrame;

  assert_sync_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> !frameSync);
  assert_state_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    stateCnt < spfLat);
  assert_frame_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !frameSync |=> $stable(frameIdx));
  assert_frame_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && frameIdx == fpiLat) |=> (frameIdx == FRAME_ONE));
  assert_geom_fixed_R10: assert property (@(posedge clk) disable iff (!rstN)
    $stable(spfLat) && $stable(fpiLat));
endmodule

// File: rtl/chop_seq_dpath.sv
module chop_seq_dpath
  import chop_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  seqStrobe_t strobe,
  output logic       chopPol,
  output logic       chopClk,
  output logic       autoMode
);
  chopMode_e mode;
  logic      nextPol;
  logic      modeIsAuto;

  assign mode       = chopMode_e'(modeSel);
  assign modeIsAuto = (mode == MODE_AUTO_A) || (mode == MODE_AUTO_B);

  always_comb begin
    unique case (mode)
      MODE_LOW:  nextPol = 1'b0;
      MODE_HIGH: nextPol = 1'b1;
      default:   nextPol = strobe.preAlt ? chopPol : ~chopPol;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chopPol  <= 1'b0;
      chopClk  <= 1'b0;
      autoMode <= modeIsAuto;
    end else if (strobe.enterSettle) begin
      chopPol  <= nextPol;
      chopClk  <= nextPol;
      autoMode <= modeIsAuto;
    end
  end

  assert_pol_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.enterSettle |=> $stable(chopPol));
  assert_fixed_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.enterSettle && modeSel == 2'b01) |=> (!chopPol && !chopClk));
  assert_fixed_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.enterSettle && modeSel == 2'b10) |=> (chopPol && chopClk));
  assert_auto_flip_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.enterSettle && modeIsAuto && !strobe.preAlt) |=> (chopPol != $past(chopPol)));
  assert_auto_skip_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.enterSettle && modeIsAuto && strobe.preAlt) |=> $stable(chopPol));
  assert_clk_follow_R11: assert property (@(posedge clk) disable iff (!rstN)
    chopClk == chopPol);
endmodule

// File: rtl/chop_frame_seq.sv
module chop_frame_seq
  import chop_seq_pkg::*;
#(
  parameter int STATE_W = 8,
  parameter int FRAME_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         modeSel,
  input  logic [STATE_W-1:0] statesPerFrame,
  input  logic [FRAME_W-1:0] framesPerInterval,
  output logic               chopPol,
  output logic               chopClk,
  output logic               frameSync,
  output logic               altFrame,
  output logic [FRAME_W-1:0] frameIdx
);
  seqStrobe_t strobe;
  logic       autoMode;

  chop_seq_ctrl #(.STATE_W(STATE_W), .FRAME_W(FRAME_W)) u_ctrl (
    .clk              (clk),
    .rstN             (rstN),
    .statesPerFrame   (statesPerFrame),
    .framesPerInterval(framesPerInterval),
    .autoMode         (autoMode),
    .strobe           (strobe),
    .frameSync        (frameSync),
    .altFrame         (altFrame),
    .frameIdx         (frameIdx)
  );

  chop_seq_dpath u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .strobe  (strobe),
    .chopPol (chopPol),
    .chopClk (chopClk),
    .autoMode(autoMode)
  );

  assert_alt_not_settle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(altFrame && frameSync));
endmodule

// File: tb/test_chop_frame_seq.sv
`timescale 1ns/1ps
module test_chop_frame_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeSel = 2'b00;
  logic [7:0]  spf = 8'd3;
  logic [11:0] fpi = 12'd4;
  logic        chopPol, chopClk, frameSync, altFrame;
  logic [11:0] frameIdx;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  chop_frame_seq i_chop_frame_seq (
    .clk(clk), .rstN(rstN), .modeSel(modeSel),
    .statesPerFrame(spf), .framesPerInterval(fpi),
    .chopPol(chopPol), .chopClk(chopClk), .frameSync(frameSync),
    .altFrame(altFrame), .frameIdx(frameIdx)
  );

  // {cycle after reset release, frameIdx, frameSync, altFrame, chopPol}
  // mode 00, 3 states per frame, 4 frames per interval
  localparam int VEC [16][5] = '{
    '{ 0, 1, 0, 0, 0}, '{ 3, 1, 1, 0, 1}, '{ 4, 2, 0, 0, 1}, '{ 7, 2, 1, 0, 0},
    '{ 8, 3, 0, 0, 0}, '{11, 3, 1, 0, 0}, '{12, 4, 0, 1, 0}, '{14, 4, 0, 1, 0},
    '{15, 4, 1, 0, 1}, '{16, 1, 0, 0, 1}, '{19, 1, 1, 0, 0}, '{23, 2, 1, 0, 1},
    '{27, 3, 1, 0, 1}, '{28, 4, 0, 1, 1}, '{31, 4, 1, 0, 0}, '{32, 1, 0, 0, 0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] m, input int s, input int f);
    rstN = 1'b0;
    modeSel = m;
    spf = 8'(s);
    fpi = 12'(f);
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic release_rst();
    rstN = 1'b1;
    cyc = 0;
  endtask

  task automatic stepTo(input int target);
    while (cyc < target) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    int altPolA;
    // R1: reset state
    doReset(2'b00, 3, 4);
    chk("R1 chopPol", int'(chopPol), 0);
    chk("R1 chopClk", int'(chopClk), 0);
    chk("R1 frameSync", int'(frameSync), 0);
    chk("R1 altFrame", int'(altFrame), 0);
    chk("R1 frameIdx", int'(frameIdx), 1);
    release_rst();
    // R10: geometry changed after reset must not matter
    spf = 8'd6;
    fpi = 12'd7;
    altPolA = -1;
    for (int i = 0; i < 16; i++) begin
      stepTo(VEC[i][0]);
      chk("R9 frameIdx", int'(frameIdx), VEC[i][1]);
      chk("R2 frameSync", int'(frameSync), VEC[i][2]);
      chk("R6 altFrame", int'(altFrame), VEC[i][3]);
      chk("R5 chopPol", int'(chopPol), VEC[i][4]);
      chk("R11 chopClk", int'(chopClk), int'(chopPol));
      if (VEC[i][0] == 12) altPolA = int'(chopPol);
      if (VEC[i][0] == 28) chk("R7 alt polarity opposite", int'(chopPol), 1 - altPolA);
    end
    chk("R10 geometry held", int'(frameIdx), 1);

    // R8: mode 11 behaves as mode 00
    doReset(2'b11, 3, 4);
    release_rst();
    stepTo(3);
    chk("R8 chopPol toggled", int'(chopPol), 1);
    stepTo(11);
    chk("R8 skip before alt", int'(chopPol), 0);
    stepTo(12);
    chk("R8 altFrame", int'(altFrame), 1);

    // R3/R4: fixed modes, change only at settle
    doReset(2'b00, 3, 4);
    release_rst();
    stepTo(1);
    modeSel = 2'b10;
    stepTo(2);
    chk("R3 no change before settle", int'(chopPol), 0);
    stepTo(3);
    chk("R4 high pol", int'(chopPol), 1);
    chk("R4 high clk", int'(chopClk), 1);
    stepTo(7);
    chk("R4 high held", int'(chopPol), 1);
    stepTo(11);
    chk("R4 high held before alt", int'(chopPol), 1);
    stepTo(12);
    chk("R6 no alt in fixed mode", int'(altFrame), 0);
    modeSel = 2'b01;
    stepTo(14);
    chk("R3 no change mid frame", int'(chopPol), 1);
    stepTo(15);
    chk("R4 low pol", int'(chopPol), 0);
    chk("R4 low clk", int'(chopClk), 0);
    stepTo(19);
    chk("R4 low held", int'(chopPol), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog cycle %0d actual hung expected done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule